// File: doc/BRIEF.md
# Arithmetic-Logic Unit with Packed Status and Control Flags

This block is a single-cycle integer arithmetic and logic unit with a clocked flags register. Each accepted operation combines two operands with one of eight operations (two additions, two subtractions, three bitwise operations and a compare). The block registers the result, and it also registers a 16-bit flags word. That word packs six status flags derived from the operation with three control flags. The control flags are written only by explicit set and clear commands.

Operations enter as a stream. The block has no back-pressure: it accepts one operation in every cycle in which `in_valid` is high. One cycle later `res_valid` pulses, and `result` and `flags` then show the effect of that operation. While `in_valid` is low nothing changes. Two operations chain through the stored carry: add-with-carry and subtract-with-borrow consume the carry flag left by the previous accepted operation. This is how multi-word arithmetic is built.

Top module: `arith_flag_unit`

## Requirements
- R1: Opcode 0 (add) and opcode 1 (add-with-carry) produce the operand sum modulo 2^W. Carry (flags bit 0) is 1 exactly when the unsigned sum exceeds 2^W-1.
- R2: Opcode 2 (subtract) and opcode 3 (subtract-with-borrow) produce A minus B modulo 2^W. Carry (bit 0) is 1 exactly when the unsigned difference is negative, which signals a borrow.
- R3: Overflow (bit 11) is 1 when the two's-complement result of an add, subtract or compare lies outside the signed W-bit range.
- R4: Sign (bit 7) equals the most significant bit of the operation's value. Zero (bit 6) is 1 exactly when that value is all zeros.
- R5: Auxiliary carry (bit 4) is 1 on a carry out of bit 3 when adding, or on a borrow into bit 3 when subtracting or comparing.
- R6: Parity (bit 2) is 1 when the low 8 bits of the value hold an even number of ones.
- R7: Opcodes 4, 5 and 6 produce A AND B, A OR B and A XOR B. Each of them clears carry, overflow and auxiliary carry.
- R8: Opcode 7 (compare) sets every status flag as subtract would. The `result` output keeps its previous value.
- R9: The flags word has bit 1 fixed at 1, and bits 3, 5 and 12 to 15 fixed at 0. After reset the flags word is 0x0002 and `result` is 0.
- R10: `result` and `flags` change only on a clock edge where `in_valid` is high. Operands, opcode and flag commands offered while it is low have no effect.
- R11: The control-flag command masks use bit 0 for trap (flags bit 8), bit 1 for interrupt enable (bit 9) and bit 2 for direction (bit 10). These flags change only through an accepted set or clear command. When a flag has both its set and clear bits raised, set wins. Arithmetic results never change them.
- R12: `res_valid` is high in exactly the cycle after each cycle in which `in_valid` was high.
- R13: Add-with-carry adds the stored carry flag as an extra 1. Subtract-with-borrow subtracts it as an extra 1. Plain add, subtract and compare ignore it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation offered this cycle; always accepted |
| op | input | 3 | Opcode 0..7 (add, adc, sub, sbb, and, or, xor, cmp) |
| opnd_a | input | W | First operand |
| opnd_b | input | W | Second operand |
| ctl_set | input | 3 | Control-flag set mask {direction, int-enable, trap} |
| ctl_clr | input | 3 | Control-flag clear mask {direction, int-enable, trap} |
| res_valid | output | 1 | Pulses one cycle after an accepted operation |
| result | output | W | Registered result of the last non-compare operation |
| flags | output | 16 | Packed status and control flags |

## Verification
The bench runs every value of A against twelve values of B for each opcode at a W of 8. The fixed values of B are zero, one, the nibble and byte edges, the sign boundary and alternating patterns. B also takes A itself and the complement of A. The edges separate a carry out of the word from a carry out of the nibble, and signed overflow from unsigned carry. B equal to A separates zero results. The complement makes all-ones sums and parity extremes. The carry is chained from one operation to the next, so a wrong carry source for add-with-carry and subtract-with-borrow shows up. Directed command sequences separate set from clear, the set-wins rule, and command masks ignored while no operation is accepted.

// File: rtl/afu_pkg.sv
package afu_pkg;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_ADC = 3'd1,
    OP_SUB = 3'd2,
    OP_SBB = 3'd3,
    OP_AND = 3'd4,
    OP_OR  = 3'd5,
    OP_XOR = 3'd6,
    OP_CMP = 3'd7
  } afu_op_e;

  localparam int FLAG_W  = 16;
  localparam int NCTL    = 3;

  // bit positions inside the packed flags word
  localparam int FB_CF   = 0;
  localparam int FB_ONE  = 1;
  localparam int FB_PF   = 2;
  localparam int FB_AF   = 4;
  localparam int FB_ZF   = 6;
  localparam int FB_SF   = 7;
  localparam int FB_TF   = 8;
  localparam int FB_IF   = 9;
  localparam int FB_DF   = 10;
  localparam int FB_OF   = 11;

  // command mask bit order
  localparam int CB_TF   = 0;
  localparam int CB_IF   = 1;
  localparam int CB_DF   = 2;

  typedef struct packed {
    logic cf;
    logic pf;
    logic af;
    logic zf;
    logic sf;
    logic of;
  } afu_stat_t;

endpackage

// File: rtl/afu_addsub.sv
module afu_addsub #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  input  logic         carry_in,
  output logic [W-1:0] sum,
  output logic         cf,
  output logic         af,
  output logic         of
);
  localparam int NIB = 4;

  logic [W-1:0] b_eff;
  logic         cin;
  logic [W:0]   full;
  logic [NIB:0] nib;

  // subtraction is a + ~b + 1, with the borrow folded in as an inverted carry
  assign b_eff = sub ? ~b : b;
  assign cin   = sub ? ~carry_in : carry_in;
  assign full  = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, cin};
  assign nib   = {1'b0, a[NIB-1:0]} + {1'b0, b_eff[NIB-1:0]} + {{NIB{1'b0}}, cin};

  assign sum = full[W-1:0];
  assign cf  = full[W] ^ sub;
  assign af  = nib[NIB] ^ sub;
  assign of  = (a[W-1] == b_eff[W-1]) && (full[W-1] != a[W-1]);
endmodule

// File: rtl/afu_logic.sv
module afu_logic #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [1:0]   sel,
  output logic [W-1:0] y
);
  always_comb begin
    unique case (sel)
      2'd0:    y = a & b;
      2'd1:    y = a | b;
      2'd2:    y = a ^ b;
      default: y = a & b;
    endcase
  end
endmodule

// File: rtl/afu_status.sv
module afu_status #(
  parameter int W = 16
) (
  input  logic [W-1:0] val,
  output logic         zf,
  output logic         sf,
  output logic         pf
);
  localparam int PW = (W < 8) ? W : 8;

  assign zf = (val == '0);
  assign sf = val[W-1];

  generate
    if (PW == W) begin : g_par_full
      assign pf = ~^val;
    end else begin : g_par_low
      assign pf = ~^val[PW-1:0];
    end
  endgenerate
endmodule

// File: rtl/arith_flag_unit.sv
module arith_flag_unit
  import afu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [2:0]   op,
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  input  logic [2:0]   ctl_set,
  input  logic [2:0]   ctl_clr,
  output logic         res_valid,
  output logic [W-1:0] result,
  output logic [15:0]  flags
);
  afu_op_e     op_e;
  logic        is_arith;
  logic        is_sub;
  logic        use_cf;
  logic [W-1:0] as_sum;
  logic        as_cf, as_af, as_of;
  logic [W-1:0] lg_y;
  logic [W-1:0] val;
  logic        st_zf, st_sf, st_pf;
  afu_stat_t   stat_d, stat_q;
  logic [NCTL-1:0] ctl_q;
  logic [W-1:0] res_q;
  logic        vld_q;

  assign op_e     = afu_op_e'(op);
  assign is_arith = ~op[2] | (op_e == OP_CMP);
  assign is_sub   = (op_e == OP_SUB) || (op_e == OP_SBB) || (op_e == OP_CMP);
  assign use_cf   = (op_e == OP_ADC) || (op_e == OP_SBB);

  afu_addsub #(.W(W)) u_addsub (
    .a        (opnd_a),
    .b        (opnd_b),
    .sub      (is_sub),
    .carry_in (use_cf & stat_q.cf),
    .sum      (as_sum),
    .cf       (as_cf),
    .af       (as_af),
    .of       (as_of)
  );

  afu_logic #(.W(W)) u_logic (
    .a   (opnd_a),
    .b   (opnd_b),
    .sel (op[1:0]),
    .y   (lg_y)
  );

  assign val = is_arith ? as_sum : lg_y;

  afu_status #(.W(W)) u_status (
    .val (val),
    .zf  (st_zf),
    .sf  (st_sf),
    .pf  (st_pf)
  );

  always_comb begin
    stat_d.cf = is_arith & as_cf;
    stat_d.af = is_arith & as_af;
    stat_d.of = is_arith & as_of;
    stat_d.zf = st_zf;
    stat_d.sf = st_sf;
    stat_d.pf = st_pf;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      res_q  <= '0;
      stat_q <= '0;
    end else begin
      vld_q <= in_valid;
      if (in_valid) begin
        stat_q <= stat_d;
        if (op_e != OP_CMP) res_q <= val;
      end
    end
  end

  // one storage cell per control flag; set outranks clear
  generate
    for (genvar i = 0; i < NCTL; i++) begin : g_ctl
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q[i] <= 1'b0;
        else if (in_valid && ctl_set[i]) ctl_q[i] <= 1'b1;
        else if (in_valid && ctl_clr[i]) ctl_q[i] <= 1'b0;
      end
    end
  endgenerate

  always_comb begin
    flags         = '0;
    flags[FB_ONE] = 1'b1;
    flags[FB_CF]  = stat_q.cf;
    flags[FB_PF]  = stat_q.pf;
    flags[FB_AF]  = stat_q.af;
    flags[FB_ZF]  = stat_q.zf;
    flags[FB_SF]  = stat_q.sf;
    flags[FB_OF]  = stat_q.of;
    flags[FB_TF]  = ctl_q[CB_TF];
    flags[FB_IF]  = ctl_q[CB_IF];
    flags[FB_DF]  = ctl_q[CB_DF];
  end

  assign res_valid = vld_q;
  assign result    = res_q;
endmodule

// File: rtl/afu_checker.sv
module afu_checker
  import afu_pkg::*;
#(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic [2:0]   op,
  input logic [2:0]   ctl_set,
  input logic [2:0]   ctl_clr,
  input logic         res_valid,
  input logic [W-1:0] result,
  input logic [15:0]  flags
);
  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(result) && $stable(flags)));

  p_cmp_keeps_result_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 3'd7) |=> $stable(result));

  p_ctl_untouched_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && ctl_set == 3'b000 && ctl_clr == 3'b000) |=> $stable(flags[FB_OF-1:FB_TF]));

  p_set_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && ctl_set[CB_DF]) |=> flags[FB_DF]);

  p_zero_tracks_result_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op != 3'd7) |=> (flags[FB_ZF] == (result == '0)));

  p_sign_tracks_result_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op != 3'd7) |=> (flags[FB_SF] == result[W-1]));

  p_logic_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op[2] && op != 3'd7) |=> (!flags[FB_CF] && !flags[FB_OF] && !flags[FB_AF]));

  p_res_valid_r12: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> res_valid);

  p_no_res_valid_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !res_valid);
endmodule

bind arith_flag_unit afu_checker #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .op        (op),
  .ctl_set   (ctl_set),
  .ctl_clr   (ctl_clr),
  .res_valid (res_valid),
  .result    (result),
  .flags     (flags)
);

// File: tb/arith_flag_unit_test.sv
module arith_flag_unit_test;
  localparam int W    = 8;
  localparam int MASK = (1 << W) - 1;
  localparam int HALF = 1 << (W - 1);

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [2:0]   op = 3'd0;
  logic [W-1:0] opnd_a = '0;
  logic [W-1:0] opnd_b = '0;
  logic [2:0]   ctl_set = 3'd0;
  logic [2:0]   ctl_clr = 3'd0;
  logic         res_valid;
  logic [W-1:0] result;
  logic [15:0]  flags;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  int       exp_res = 0;
  int       m_cf = 0, m_pf = 0, m_af = 0, m_zf = 0, m_sf = 0, m_of = 0;
  bit [2:0] m_ctl = 3'b000;

  always #5 clk = ~clk;

  arith_flag_unit #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .ctl_set(ctl_set), .ctl_clr(ctl_clr),
    .res_valid(res_valid), .result(result), .flags(flags)
  );

  function automatic int exp_flags();
    int f;
    f = 2;
    f |= m_cf << 0;
    f |= m_pf << 2;
    f |= m_af << 4;
    f |= m_zf << 6;
    f |= m_sf << 7;
    f |= int'(m_ctl[0]) << 8;
    f |= int'(m_ctl[1]) << 9;
    f |= int'(m_ctl[2]) << 10;
    f |= m_of << 11;
    return f;
  endfunction

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic check_all(string ctag);
    int f;
    f = exp_flags();
    check({ctag, " result"}, int'(result), exp_res);
    check("R9 flags word", int'(flags), f);
    check({ctag, " carry"}, int'(flags[0]), m_cf);
    check("R3 overflow", int'(flags[11]), m_of);
    check("R4 sign", int'(flags[7]), m_sf);
    check("R4 zero", int'(flags[6]), m_zf);
    check("R5 aux carry", int'(flags[4]), m_af);
    check("R6 parity", int'(flags[2]), m_pf);
    check("R11 control flags", int'(flags[10:8]), int'(m_ctl));
  endtask

  task automatic run_op(int o, int a, int b, bit [2:0] s, bit [2:0] c);
    int cin, r, sa, sb, ss, d;
    string tag;
    sa = (a >= HALF) ? a - (1 << W) : a;
    sb = (b >= HALF) ? b - (1 << W) : b;
    r  = 0;
    case (o)
      0, 1: begin
        cin  = (o == 1) ? m_cf : 0;
        d    = a + b + cin;
        r    = d & MASK;
        m_cf = (d > MASK) ? 1 : 0;
        m_af = (((a & 15) + (b & 15) + cin) > 15) ? 1 : 0;
        ss   = sa + sb + cin;
        m_of = (ss >= HALF || ss < -HALF) ? 1 : 0;
      end
      2, 3, 7: begin
        cin  = (o == 3) ? m_cf : 0;
        d    = a - b - cin;
        r    = d & MASK;
        m_cf = (d < 0) ? 1 : 0;
        m_af = (((a & 15) - (b & 15) - cin) < 0) ? 1 : 0;
        ss   = sa - sb - cin;
        m_of = (ss >= HALF || ss < -HALF) ? 1 : 0;
      end
      default: begin
        if (o == 4) r = a & b;
        else if (o == 5) r = a | b;
        else r = a ^ b;
        m_cf = 0; m_af = 0; m_of = 0;
      end
    endcase
    m_zf = (r == 0) ? 1 : 0;
    m_sf = (r >> (W - 1)) & 1;
    m_pf = ($countones(r & 255) % 2 == 0) ? 1 : 0;
    for (int i = 0; i < 3; i++) begin
      if (s[i]) m_ctl[i] = 1'b1;
      else if (c[i]) m_ctl[i] = 1'b0;
    end
    if (o != 7) exp_res = r;
    case (o)
      0: tag = "R1";
      1, 3: tag = "R13";
      2: tag = "R2";
      7: tag = "R8";
      default: tag = "R7";
    endcase
    @(negedge clk);
    in_valid = 1'b1;
    op       = 3'(o);
    opnd_a   = W'(a);
    opnd_b   = W'(b);
    ctl_set  = s;
    ctl_clr  = c;
    @(posedge clk);
    #1;
    check("R12 res_valid after accept", int'(res_valid), 1);
    check_all(tag);
  endtask

  task automatic idle(int a, int b, bit [2:0] s, bit [2:0] c);
    @(negedge clk);
    in_valid = 1'b0;
    op       = 3'd1;
    opnd_a   = W'(a);
    opnd_b   = W'(b);
    ctl_set  = s;
    ctl_clr  = c;
    @(posedge clk);
    #1;
    check("R12 res_valid idle", int'(res_valid), 0);
    check("R10 result held", int'(result), exp_res);
    check("R10 flags held", int'(flags), exp_flags());
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int bv [12];
    repeat (3) @(posedge clk);
    #1;
    check("R9 reset result", int'(result), 0);
    check("R9 reset flags", int'(flags), 16'h0002);
    check("R12 reset res_valid", int'(res_valid), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    check("R9 flags after release", int'(flags), 16'h0002);

    // control flag commands
    run_op(0, 1, 2, 3'b100, 3'b000);
    run_op(0, 3, 4, 3'b001, 3'b000);
    idle(5, 6, 3'b010, 3'b101);
    run_op(4, 15, 240, 3'b000, 3'b100);
    run_op(5, 0, 0, 3'b010, 3'b010);
    run_op(6, 255, 255, 3'b000, 3'b111);
    run_op(0, 127, 1, 3'b111, 3'b111);
    run_op(2, 0, 1, 3'b000, 3'b011);

    // sweeps over opcode and operand patterns, carry chained between steps
    for (int o = 0; o < 8; o++) begin
      for (int a = 0; a < 256; a++) begin
        bv = '{0, 1, 15, 16, 127, 128, 255, 254, 85, 170, a, (~a) & 255};
        for (int k = 0; k < 12; k++) begin
          run_op(o, a, bv[k], 3'b000, 3'b000);
        end
        if (a % 37 == 0) idle(a, 255 - a, 3'b111, 3'b000);
      end
    end

    // compare after a known result keeps it
    run_op(0, 100, 50, 3'b000, 3'b000);
    run_op(7, 50, 100, 3'b000, 3'b000);
    run_op(3, 10, 10, 3'b000, 3'b000);

    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule